// File: doc/BRIEF.md
# Out-of-Order Issue Window with Selectable Select Policy

This block is the waiting room between rename and the pipelined functional units of a superscalar core. Each cycle it takes in up to `W` renamed instructions. Each instruction carries:

- two source physical tags, each with a "value already present" flag;
- a destination physical tag;
- an opaque payload holding the operand values and opcode, read from the register file as the instruction enters.

Entries watch `W` result-forwarding buses. When a bus carries a tag that an entry is waiting on, that source turns ready. Each cycle the window hands up to `W` ready entries to the functional units, one per issue lane.

A static mode pin picks the select policy. When it is low, selection follows strict program order: only the oldest not-yet-issued entries may go, and selection halts at the first one that is still waiting. When it is high, the oldest ready entries go first, and waiting entries are skipped. Age is kept in an age matrix. An issued entry keeps its slot until a forwarding bus carries its own destination tag, which signals that execution has finished.

The insert side uses valid/ready handshakes. `ins_ready` depends on how many lanes of `ins_valid` are raised. It is high only when the free slots number at least that many. A request is taken whole, all raised lanes in the same cycle, or not at all. The issue side has no back-pressure, because there are as many pipelined units as lanes. The mode pin is meant to change only while reset is asserted.

Top module: `sched_window`

## Requirements
- R1: After reset every issue lane is idle and, with no lane requesting, `ins_ready` is high.
- R2: `ins_ready` is high exactly when the free slots are at least the number of raised `ins_valid` lanes. When it is high, every raised lane is stored in that cycle. When it is low, none is stored.
- R3: An instruction inserted with both sources flagged ready can appear on an issue lane in the cycle right after the one in which it was inserted.
- R4: A source that a forwarding bus carries in cycle t counts as ready from cycle t+1. A dependent whose last operand arrives that way issues no earlier than cycle t+1.
- R5: A forwarding bus that carries a source's tag in the same cycle as that instruction's insertion marks the source ready. The broadcast is not lost.
- R6: At most `W` entries issue per cycle, filling lanes from lane 0 upward with no gaps. Among the chosen entries, lane 0 carries the oldest.
- R7: With `policy_ooo` = 0, only a contiguous run of the oldest unissued entries may issue. Selection stops at the first unissued entry that is not ready, even when younger entries are ready.
- R8: With `policy_ooo` = 1, the oldest ready unissued entries issue first, and entries still waiting are skipped.
- R9: An issued entry is never selected again. It keeps its slot until a forwarding bus carries its destination tag, and only then may the slot accept a new instruction.
- R10: When every slot is occupied, `ins_ready` is low for any non-empty request, and an offered instruction neither enters nor issues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_ooo | input | 1 | Select policy: 0 program order, 1 oldest-ready-first |
| ins_valid | input | W | Per-lane insert request |
| ins_ready | output | 1 | Whole request can be taken this cycle |
| ins_dst | input | W×TAG_W | Destination physical tag per lane |
| ins_src_a | input | W×TAG_W | First source tag per lane |
| ins_src_a_rdy | input | W | First source value already present |
| ins_src_b | input | W×TAG_W | Second source tag per lane |
| ins_src_b_rdy | input | W | Second source value already present |
| ins_info | input | W×INFO_W | Payload read at insertion (operands, opcode) |
| fwd_valid | input | W | Forwarding bus carries a result |
| fwd_tag | input | W×TAG_W | Tag of the forwarded result |
| iss_valid | output | W | Issue lane carries an instruction |
| iss_dst | output | W×TAG_W | Destination tag of the issued instruction |
| iss_info | output | W×INFO_W | Payload of the issued instruction |

## Verification
Insertion and wakeup each land on a clock edge, and selection is combinational from the stored state. A ready instruction inserted in cycle c therefore shows on an issue lane in cycle c+1. A forwarded tag in cycle t releases its dependents in cycle t+1. A full group of more than `W` ready entries drains over consecutive cycles, oldest first.

The bench drives inputs just after a rising edge and records, for each item it expects, the cycle and lane in which that item must appear. A monitor samples the lanes on the falling edge. It flags anything early, late, on the wrong lane or unexpected. Handshake answers are combinational, so they are sampled in the same cycle the request is offered.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {
    POL_INORDER = 1'b0,
    POL_OOO     = 1'b1
  } policy_e;

  // population count over a vector of up to 64 bits
  function automatic int pop64(input logic [63:0] v);
    int n;
    n = 0;
    for (int b = 0; b < 64; b++) n += int'(v[b]);
    return n;
  endfunction

endpackage

// File: rtl/sched_alloc.sv
module sched_alloc
  import sched_pkg::*;
#(
  parameter int W = 2,
  parameter int E = 8
) (
  input  logic [E-1:0]        free_vec,
  input  logic [W-1:0]        want,
  output logic                room,
  output logic [W-1:0][E-1:0] grant
);

  int free_pos [E];
  int lane_pos [W];
  int nfree;
  int nlane;

  // rank each free slot and each requesting lane; the k-th lane takes the k-th free slot
  always_comb begin
    nfree = 0;
    for (int i = 0; i < E; i++) begin
      free_pos[i] = nfree;
      if (free_vec[i]) nfree++;
    end
    nlane = 0;
    for (int k = 0; k < W; k++) begin
      lane_pos[k] = nlane;
      if (want[k]) nlane++;
    end
    room = (nfree >= pop64(64'(want)));
    for (int k = 0; k < W; k++)
      for (int i = 0; i < E; i++)
        grant[k][i] = want[k] && free_vec[i] && (free_pos[i] == lane_pos[k]);
  end

endmodule

// File: rtl/sched_age.sv
module sched_age #(
  parameter int E = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [E-1:0]        live,
  input  logic [E-1:0]        wr,
  output logic [E-1:0][E-1:0] older
);

  // older[i][j] = 1 means slot j holds an instruction older than slot i
  for (genvar i = 0; i < E; i++) begin : g_row
    for (genvar j = 0; j < E; j++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          older[i][j] <= 1'b0;
        else if (wr[i])
          older[i][j] <= live[j] || ((j < i) && wr[j]);
        else if (wr[j])
          older[i][j] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sched_select.sv
module sched_select
  import sched_pkg::*;
#(
  parameter int W = 2,
  parameter int E = 8
) (
  input  policy_e             mode,
  input  logic [E-1:0]        cand,
  input  logic [E-1:0]        rdy,
  input  logic [E-1:0][E-1:0] older,
  output logic [E-1:0]        sel,
  output logic [W-1:0][E-1:0] pick
);

  int          ahead [E];
  logic [E-1:0] pool;
  logic [E-1:0] blk;

  always_comb begin
    // entries that compete for lanes ahead of a given one
    pool = (mode == POL_OOO) ? (cand & rdy) : cand;
    for (int i = 0; i < E; i++) begin
      ahead[i] = pop64(64'(older[i] & pool));
      blk[i]   = (mode == POL_INORDER) && (|(older[i] & cand & ~rdy));
      sel[i]   = cand[i] && rdy[i] && !blk[i] && (ahead[i] < W);
    end
    for (int k = 0; k < W; k++)
      for (int i = 0; i < E; i++)
        pick[k][i] = sel[i] && (ahead[i] == k);
  end

endmodule

// File: rtl/sched_window.sv
module sched_window
  import sched_pkg::*;
#(
  parameter int W      = 2,
  parameter int E      = 8,
  parameter int TAG_W  = 6,
  parameter int INFO_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     policy_ooo,
  input  logic [W-1:0]             ins_valid,
  output logic                     ins_ready,
  input  logic [W-1:0][TAG_W-1:0]  ins_dst,
  input  logic [W-1:0][TAG_W-1:0]  ins_src_a,
  input  logic [W-1:0]             ins_src_a_rdy,
  input  logic [W-1:0][TAG_W-1:0]  ins_src_b,
  input  logic [W-1:0]             ins_src_b_rdy,
  input  logic [W-1:0][INFO_W-1:0] ins_info,
  input  logic [W-1:0]             fwd_valid,
  input  logic [W-1:0][TAG_W-1:0]  fwd_tag,
  output logic [W-1:0]             iss_valid,
  output logic [W-1:0][TAG_W-1:0]  iss_dst,
  output logic [W-1:0][INFO_W-1:0] iss_info
);

  // slot state
  logic [E-1:0]        e_vld, e_iss, e_ra, e_rb;
  logic [TAG_W-1:0]    e_ta [E];
  logic [TAG_W-1:0]    e_tb [E];
  logic [TAG_W-1:0]    e_dst [E];
  logic [INFO_W-1:0]   e_info [E];

  // insertion path
  logic                room, accept;
  logic [W-1:0][E-1:0] grant;
  logic [E-1:0]        wr;
  logic [TAG_W-1:0]    w_ta [E];
  logic [TAG_W-1:0]    w_tb [E];
  logic [TAG_W-1:0]    w_dst [E];
  logic [INFO_W-1:0]   w_info [E];
  logic [E-1:0]        w_ra, w_rb;

  // wakeup / select
  logic [E-1:0]        hit_a, hit_b, hit_d, hit_wa, hit_wb;
  logic [E-1:0][E-1:0] older;
  logic [E-1:0]        sel_vec;
  logic [W-1:0][E-1:0] pick;

  function automatic logic on_bus(input logic [TAG_W-1:0]         t,
                                  input logic [W-1:0]             v,
                                  input logic [W-1:0][TAG_W-1:0]  tg);
    logic h;
    h = 1'b0;
    for (int b = 0; b < W; b++)
      if (v[b] && (tg[b] == t)) h = 1'b1;
    return h;
  endfunction

  sched_alloc #(.W(W), .E(E)) u_alloc (
    .free_vec (~e_vld),
    .want     (ins_valid),
    .room     (room),
    .grant    (grant)
  );

  assign ins_ready = room;
  assign accept    = room && (|ins_valid);

  // route each granted lane's fields to its slot
  always_comb begin
    for (int i = 0; i < E; i++) begin
      w_ta[i]   = '0;
      w_tb[i]   = '0;
      w_dst[i]  = '0;
      w_info[i] = '0;
      w_ra[i]   = 1'b0;
      w_rb[i]   = 1'b0;
      wr[i]     = 1'b0;
      for (int k = 0; k < W; k++) begin
        if (grant[k][i]) begin
          w_ta[i]   = ins_src_a[k];
          w_tb[i]   = ins_src_b[k];
          w_dst[i]  = ins_dst[k];
          w_info[i] = ins_info[k];
          w_ra[i]   = ins_src_a_rdy[k];
          w_rb[i]   = ins_src_b_rdy[k];
          wr[i]     = accept;
        end
      end
    end
  end

  // tag comparison against all forwarding buses
  always_comb begin
    for (int i = 0; i < E; i++) begin
      hit_a[i]  = on_bus(e_ta[i],  fwd_valid, fwd_tag);
      hit_b[i]  = on_bus(e_tb[i],  fwd_valid, fwd_tag);
      hit_d[i]  = on_bus(e_dst[i], fwd_valid, fwd_tag);
      hit_wa[i] = on_bus(w_ta[i],  fwd_valid, fwd_tag);
      hit_wb[i] = on_bus(w_tb[i],  fwd_valid, fwd_tag);
    end
  end

  sched_age #(.E(E)) u_age (
    .clk   (clk),
    .rst_n (rst_n),
    .live  (e_vld),
    .wr    (wr),
    .older (older)
  );

  sched_select #(.W(W), .E(E)) u_sel (
    .mode  (policy_e'(policy_ooo)),
    .cand  (e_vld & ~e_iss),
    .rdy   (e_ra & e_rb),
    .older (older),
    .sel   (sel_vec),
    .pick  (pick)
  );

  // slot update: insert, mark issued, wake sources, release on completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld <= '0;
      e_iss <= '0;
      e_ra  <= '0;
      e_rb  <= '0;
      for (int i = 0; i < E; i++) begin
        e_ta[i]   <= '0;
        e_tb[i]   <= '0;
        e_dst[i]  <= '0;
        e_info[i] <= '0;
      end
    end else begin
      for (int i = 0; i < E; i++) begin
        if (wr[i]) begin
          e_vld[i]  <= 1'b1;
          e_iss[i]  <= 1'b0;
          e_ta[i]   <= w_ta[i];
          e_tb[i]   <= w_tb[i];
          e_dst[i]  <= w_dst[i];
          e_info[i] <= w_info[i];
          e_ra[i]   <= w_ra[i] || hit_wa[i];
          e_rb[i]   <= w_rb[i] || hit_wb[i];
        end else begin
          if (sel_vec[i]) e_iss[i] <= 1'b1;
          if (e_vld[i] && e_iss[i] && hit_d[i]) e_vld[i] <= 1'b0;
          if (hit_a[i]) e_ra[i] <= 1'b1;
          if (hit_b[i]) e_rb[i] <= 1'b1;
        end
      end
    end
  end

  // issue lanes
  always_comb begin
    for (int k = 0; k < W; k++) begin
      iss_valid[k] = |pick[k];
      iss_dst[k]   = '0;
      iss_info[k]  = '0;
      for (int i = 0; i < E; i++) begin
        if (pick[k][i]) begin
          iss_dst[k]  = e_dst[i];
          iss_info[k] = e_info[i];
        end
      end
    end
  end

endmodule

// File: rtl/sched_window_chk.sv
module sched_window_chk #(
  parameter int W = 2,
  parameter int E = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                policy_ooo,
  input logic [W-1:0]        ins_valid,
  input logic                ins_ready,
  input logic [W-1:0]        iss_valid,
  input logic [E-1:0]        e_vld,
  input logic [E-1:0]        e_iss,
  input logic [E-1:0]        e_ra,
  input logic [E-1:0]        e_rb,
  input logic [E-1:0]        sel_vec,
  input logic [E-1:0][E-1:0] older
);

  logic [W-1:0] took;
  assign took = ins_ready ? ins_valid : '0;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (iss_valid == '0)) else $error("issue after reset"); // R1

  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_valid + W'(1)) & iss_valid) == '0) else $error("issue lanes not packed"); // R6

  AST_OCC_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(e_vld) <= $past($countones(e_vld)) + $past($countones(took))))
    else $error("occupancy grew beyond accepted"); // R2

  AST_OCC_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(e_vld) + W >= $past($countones(e_vld)) + $past($countones(took))))
    else $error("more slots released than buses"); // R9

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((&e_vld) && (ins_valid != '0)) |-> !ins_ready) else $error("accept while full"); // R10

  AST_OOO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_ooo && (|(e_vld & ~e_iss & e_ra & e_rb & ~sel_vec))) |-> (&iss_valid))
    else $error("ready entry left while lane free"); // R8

  for (genvar i = 0; i < E; i++) begin : g_slot
    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      sel_vec[i] |-> (e_vld[i] && !e_iss[i])) else $error("reissue"); // R9

    AST_INORDER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!policy_ooo && sel_vec[i]) |-> ((older[i] & e_vld & ~e_iss & ~sel_vec) == '0))
      else $error("in-order select skipped an older entry"); // R7
  end

endmodule

bind sched_window sched_window_chk #(.W(W), .E(E)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .policy_ooo (policy_ooo),
  .ins_valid  (ins_valid),
  .ins_ready  (ins_ready),
  .iss_valid  (iss_valid),
  .e_vld      (e_vld),
  .e_iss      (e_iss),
  .e_ra       (e_ra),
  .e_rb       (e_rb),
  .sel_vec    (sel_vec),
  .older      (older)
);

// File: tb/tb_sched_window.sv
module tb_sched_window;
  localparam int W  = 2;
  localparam int E  = 8;
  localparam int TW = 6;
  localparam int IW = 8;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  policy_ooo = 1'b0;
  logic [W-1:0]          ins_valid;
  logic                  ins_ready;
  logic [W-1:0][TW-1:0]  ins_dst, ins_src_a, ins_src_b;
  logic [W-1:0]          ins_src_a_rdy, ins_src_b_rdy;
  logic [W-1:0][IW-1:0]  ins_info;
  logic [W-1:0]          fwd_valid;
  logic [W-1:0][TW-1:0]  fwd_tag;
  logic [W-1:0]          iss_valid;
  logic [W-1:0][TW-1:0]  iss_dst;
  logic [W-1:0][IW-1:0]  iss_info;

  sched_window #(.W(W), .E(E), .TAG_W(TW), .INFO_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .policy_ooo(policy_ooo),
    .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_dst(ins_dst), .ins_src_a(ins_src_a), .ins_src_a_rdy(ins_src_a_rdy),
    .ins_src_b(ins_src_b), .ins_src_b_rdy(ins_src_b_rdy), .ins_info(ins_info),
    .fwd_valid(fwd_valid), .fwd_tag(fwd_tag),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_info(iss_info)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    int    lane;
    int    tag;
    string req;
  } exp_t;
  exp_t q[$];

  function automatic logic [IW-1:0] info_of(input int tag);
    return IW'(tag) ^ 8'h5A;
  endfunction

  task automatic clear_in();
    ins_valid = '0; ins_dst = '0; ins_src_a = '0; ins_src_b = '0;
    ins_src_a_rdy = '0; ins_src_b_rdy = '0; ins_info = '0;
    fwd_valid = '0; fwd_tag = '0;
  endtask

  task automatic put(input int l, input int dst, input int ta, input bit ra,
                     input int tb, input bit rb);
    ins_valid[l] = 1'b1;
    ins_dst[l] = TW'(dst);
    ins_src_a[l] = TW'(ta);
    ins_src_a_rdy[l] = ra;
    ins_src_b[l] = TW'(tb);
    ins_src_b_rdy[l] = rb;
    ins_info[l] = info_of(dst);
  endtask

  task automatic fwd(input int l, input int tag);
    fwd_valid[l] = 1'b1;
    fwd_tag[l] = TW'(tag);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clear_in();
  endtask

  task automatic expect_iss(input int at, input int lane, input int tag, input string req);
    exp_t e;
    e.at = at; e.lane = lane; e.tag = tag; e.req = req;
    q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic do_reset(input bit pol);
    rst_n = 1'b0;
    clear_in();
    policy_ooo = pol;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // monitor: compare issue lanes against the expected-item queue
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < W; l++) begin
        if (iss_valid[l]) begin
          total++;
          if (q.size() > 0 && q[0].at == cyc && q[0].lane == l) begin
            if (int'(iss_dst[l]) != q[0].tag || iss_info[l] != info_of(q[0].tag)) begin
              bad++;
              $display("FAIL %s lane %0d actual=%0d expected=%0d (cycle %0d)",
                       q[0].req, l, iss_dst[l], q[0].tag, cyc);
            end
            void'(q.pop_front());
          end else begin
            bad++;
            $display("FAIL %s unexpected issue lane %0d actual=%0d expected=none (cycle %0d)",
                     (q.size() > 0) ? q[0].req : "R9", l, iss_dst[l], cyc);
          end
        end
      end
      while (q.size() > 0 && q[0].at <= cyc) begin
        total++;
        bad++;
        $display("FAIL %s missing issue lane %0d actual=none expected=%0d (cycle %0d)",
                 q[0].req, q[0].lane, q[0].tag, q[0].at);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_in();

    // ---------------- out-of-order policy: basic timing ----------------
    do_reset(1'b1);
    @(negedge clk);
    chk(iss_valid == '0, "R1", int'(iss_valid), 0);
    chk(ins_ready == 1'b1, "R1", int'(ins_ready), 1);
    @(posedge clk); #1;

    put(0, 10, 1, 1, 2, 1);
    put(1, 11, 40, 0, 3, 1);
    expect_iss(cyc + 1, 0, 10, "R3");
    tick();
    fwd(0, 40);                               // last operand of 11
    expect_iss(cyc + 1, 0, 11, "R4");
    tick();
    put(0, 12, 41, 0, 4, 1);
    fwd(0, 41);                               // same-cycle broadcast
    expect_iss(cyc + 1, 0, 12, "R5");
    tick();
    put(0, 20, 42, 0, 5, 1);
    put(1, 21, 6, 1, 7, 1);
    expect_iss(cyc + 1, 0, 21, "R8");         // younger ready one goes first
    tick();
    fwd(0, 42);
    fwd(1, 10);
    expect_iss(cyc + 1, 0, 20, "R8");
    tick();
    fwd(0, 11);
    fwd(1, 12);
    put(0, 30, 43, 0, 8, 1);
    put(1, 31, 43, 0, 9, 1);
    tick();
    put(0, 32, 43, 0, 13, 1);
    fwd(0, 20);
    fwd(1, 21);
    tick();
    fwd(0, 43);                               // three become ready at once
    expect_iss(cyc + 1, 0, 30, "R6");
    expect_iss(cyc + 1, 1, 31, "R6");
    expect_iss(cyc + 2, 0, 32, "R6");
    tick();
    tick();
    tick();

    // ---------------- full window and slot release ----------------
    do_reset(1'b1);
    for (int n = 0; n < E / 2; n++) begin
      put(0, 20 + 2 * n, 50, 0, 1, 1);
      put(1, 21 + 2 * n, 50, 0, 1, 1);
      tick();
    end
    put(0, 60, 1, 1, 1, 1);
    @(negedge clk);
    chk(ins_ready == 1'b0, "R10", int'(ins_ready), 0);
    tick();                                   // 60 must never issue
    fwd(0, 50);
    for (int n = 0; n < E / 2; n++) begin
      expect_iss(cyc + 1 + n, 0, 20 + 2 * n, "R6");
      expect_iss(cyc + 1 + n, 1, 21 + 2 * n, "R6");
    end
    tick();
    repeat (E / 2) tick();
    put(0, 61, 1, 1, 1, 1);
    @(negedge clk);
    chk(ins_ready == 1'b0, "R9", int'(ins_ready), 0);
    tick();
    fwd(0, 20);                               // completion frees one slot
    tick();
    put(0, 62, 1, 1, 1, 1);
    put(1, 63, 1, 1, 1, 1);
    @(negedge clk);
    chk(ins_ready == 1'b0, "R2", int'(ins_ready), 0);
    tick();
    put(0, 62, 1, 1, 1, 1);
    @(negedge clk);
    chk(ins_ready == 1'b1, "R2", int'(ins_ready), 1);
    expect_iss(cyc + 1, 0, 62, "R2");
    tick();
    tick();
    tick();

    // ---------------- in-order policy ----------------
    do_reset(1'b0);
    put(0, 40, 44, 0, 1, 1);
    put(1, 41, 2, 1, 3, 1);                   // ready but behind a waiter
    tick();
    fwd(0, 44);
    expect_iss(cyc + 1, 0, 40, "R7");
    expect_iss(cyc + 1, 1, 41, "R7");
    tick();
    put(0, 42, 5, 1, 6, 1);
    put(1, 43, 45, 0, 7, 1);
    expect_iss(cyc + 1, 0, 42, "R7");
    tick();
    put(0, 46, 8, 1, 9, 1);                   // blocked behind 43
    tick();
    fwd(0, 45);
    expect_iss(cyc + 1, 0, 43, "R7");
    expect_iss(cyc + 1, 1, 46, "R7");
    tick();
    tick();
    tick();

    while (q.size() > 0) begin
      total++;
      bad++;
      $display("FAIL %s never issued actual=none expected=%0d", q[0].req, q[0].tag);
      void'(q.pop_front());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule